// File: doc/BRIEF.md
# Frame-Shared Edge-Programmed PWM Generator

This block drives sixteen pulse-width outputs from one common time base. A shared prescaler divides the input clock into step ticks. A shared step counter runs from zero to a programmed limit and then wraps, which defines one frame. Every output has its own pair of step indices. The output goes high when the counter arrives at the first index and low when it arrives at the second. Duty and polarity therefore come from where the two edges sit within the frame, not from a duty value.

Software sets up the block through a plain strobe interface with a word address and 32-bit data. Channels picked by a build-time mask keep staged copies of their edge and enable settings. For those channels, new settings take effect only at a frame boundary, and only after software has requested the change by writing the commit address. The other channels take every write at once.

Top module: `frame_pwm`

## Requirements
- R1: The frame lasts (S+1)·(P+1) input clocks, where S is the 8-bit value at word 0 and P is the 8-bit value at word 1. All channels share S and P. The step counter counts 0..P and wraps to 0 at each frame start.
- R2: When rise < fall, an enabled channel is high from the step equal to its rise value up to the step equal to its fall value, so it is high for (fall−rise)·(S+1) clocks per frame.
- R3: When rise > fall, the waveform is inverted: the channel is high for (P+1−(rise−fall))·(S+1) clocks per frame.
- R4: When rise equals fall, the channel toggles once per frame at that step, giving a 50% waveform whose period is two frames.
- R5: With P = 0xFE, rise = 0 and fall = 0xFF, the channel stays high for the whole frame.
- R6: A channel whose mask bit is 0 takes a new edge or enable write immediately, within the frame in progress.
- R7: A channel whose mask bit is 1 keeps its old active edge and enable values after a write. The staged values become active at the first frame start after a write to word 57. A write to word 57 has no effect on unmasked channels.
- R8: A commit request stays pending until the next frame start, is then applied once and clears. Later staged writes stay inactive until a new request.
- R9: A channel whose active enable is 0 drives its output low.
- R10: A read strobe returns the addressed register on rdata one clock later. The value is the last one written, including staged values. Word 57 reads as zero.
- R11: After reset, every register holds 0, no commit is pending, and all outputs are low.
- R12: Word map: 0 prescale, 1 period, 2 enables of channels 0–7 (bit i = channel i), 3 enables of channels 8–15 (bit i = channel 8+i), 4+2·i rise of channel i, 5+2·i fall of channel i, 57 commit. Values sit in data bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| pwm_out | output | 16 | Registered channel outputs |

## Verification
A fault in the prescaler or the step counter changes the frame length. It shows up as a wrong high-time count on every enabled channel within one frame of the fault. A staged channel that commits too early drives edges before the frame boundary. This is seen within a few steps of the commit write. A pending flag that fails to clear makes later staged writes leak out at the next frame start, so the high time changes one frame after an uncommitted write. A wrong edge compare shows up as a wrong per-frame high count on that single channel.

// File: rtl/frame_pwm_pkg.sv
package frame_pwm_pkg;
  localparam int STEP_W = 8;
  typedef logic [STEP_W-1:0] step_t;

  // word addresses
  localparam int A_PRESC     = 0;
  localparam int A_PERIOD    = 1;
  localparam int A_EN_BASE   = 2;
  localparam int A_EDGE_BASE = 4;
  localparam int A_SYNC      = 57;
endpackage

// File: rtl/frame_pwm_timebase.sv
module frame_pwm_timebase
  import frame_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_t prescale,
  input  step_t period,
  output logic  tick,
  output logic  frame_start,
  output step_t next_step,
  output step_t step
);
  step_t presc_q;

  // >= keeps the counters sane when a limit shrinks mid-frame
  assign tick        = (presc_q >= prescale);
  assign frame_start = tick && (step >= period);
  assign next_step   = frame_start ? '0 : step + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      step    <= '0;
    end else begin
      presc_q <= tick ? '0 : presc_q + 1'b1;
      if (tick) step <= next_step;
    end
  end
endmodule

// File: rtl/frame_pwm_chan.sv
module frame_pwm_chan
  import frame_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  step_t next_step,
  input  step_t rise,
  input  step_t fall,
  input  logic  en,
  output logic  out
);
  logic hit_r, hit_f;
  assign hit_r = (next_step == rise);
  assign hit_f = (next_step == fall);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      out <= 1'b0;
    end else if (tick) begin
      if (hit_r && hit_f) out <= ~out;
      else if (hit_r)     out <= 1'b1;
      else if (hit_f)     out <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_pwm_regs.sv
module frame_pwm_regs
  import frame_pwm_pkg::*;
#(
  parameter int             NCH         = 16,
  parameter int             ADDR_W      = 6,
  parameter int             DATA_W      = 32,
  parameter logic [NCH-1:0] SHADOW_MASK = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        frame_start,
  output step_t                       prescale,
  output step_t                       period,
  output logic [NCH-1:0][STEP_W-1:0]  act_rise,
  output logic [NCH-1:0][STEP_W-1:0]  act_fall,
  output logic [NCH-1:0]              act_en,
  output logic                        sync_pend,
  output logic [DATA_W-1:0]           rdata
);
  localparam int EN_WORDS = (NCH + 7) / 8;
  localparam int EN_BITS  = EN_WORDS * 8;

  logic [NCH-1:0][STEP_W-1:0] wr_rise, wr_fall;
  logic [EN_BITS-1:0]         wr_enb;
  logic                       sync_hit, commit;
  logic [DATA_W-1:0]          rd_val;
  logic                       wdata_unused;

  assign wdata_unused = ^wdata[DATA_W-1:STEP_W];
  assign sync_hit     = wr_en && (addr == ADDR_W'(A_SYNC));
  assign commit       = frame_start && sync_pend;

  // last-written copies (shared storage for both channel kinds)
  always_ff @(posedge clk) begin
    if (rst) begin
      prescale <= '0;
      period   <= '0;
      wr_enb   <= '0;
      wr_rise  <= '0;
      wr_fall  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_PRESC))  prescale <= wdata[STEP_W-1:0];
      if (addr == ADDR_W'(A_PERIOD)) period   <= wdata[STEP_W-1:0];
      for (int w = 0; w < EN_WORDS; w++)
        if (addr == ADDR_W'(A_EN_BASE + w)) wr_enb[w*8 +: 8] <= wdata[7:0];
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(A_EDGE_BASE + 2*i))     wr_rise[i] <= wdata[STEP_W-1:0];
        if (addr == ADDR_W'(A_EDGE_BASE + 2*i + 1)) wr_fall[i] <= wdata[STEP_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               sync_pend <= 1'b0;
    else if (sync_hit)     sync_pend <= 1'b1;
    else if (frame_start)  sync_pend <= 1'b0;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_act
    step_t r_q, f_q;
    logic  e_q;
    if (SHADOW_MASK[i]) begin : g_shadow
      always_ff @(posedge clk) begin
        if (rst) begin
          r_q <= '0;
          f_q <= '0;
          e_q <= 1'b0;
        end else if (commit) begin
          r_q <= wr_rise[i];
          f_q <= wr_fall[i];
          e_q <= wr_enb[i];
        end
      end
    end else begin : g_direct
      assign r_q = wr_rise[i];
      assign f_q = wr_fall[i];
      assign e_q = wr_enb[i];
    end
    assign act_rise[i] = r_q;
    assign act_fall[i] = f_q;
    assign act_en[i]   = e_q;
  end

  always_comb begin
    rd_val = '0;
    if (addr == ADDR_W'(A_PRESC))  rd_val[STEP_W-1:0] = prescale;
    if (addr == ADDR_W'(A_PERIOD)) rd_val[STEP_W-1:0] = period;
    for (int w = 0; w < EN_WORDS; w++)
      if (addr == ADDR_W'(A_EN_BASE + w)) rd_val[7:0] = wr_enb[w*8 +: 8];
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(A_EDGE_BASE + 2*i))     rd_val[STEP_W-1:0] = wr_rise[i];
      if (addr == ADDR_W'(A_EDGE_BASE + 2*i + 1)) rd_val[STEP_W-1:0] = wr_fall[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/frame_pwm.sv
module frame_pwm
  import frame_pwm_pkg::*;
#(
  parameter int             NCH         = 16,
  parameter int             ADDR_W      = 6,
  parameter int             DATA_W      = 32,
  parameter logic [NCH-1:0] SHADOW_MASK = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out
);
  step_t                      prescale, period, step, next_step;
  logic                       tick, frame_start, sync_pend;
  logic [NCH-1:0][STEP_W-1:0] act_rise, act_fall;
  logic [NCH-1:0]             act_en;

  frame_pwm_regs #(
    .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHADOW_MASK(SHADOW_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .frame_start(frame_start), .prescale(prescale),
    .period(period), .act_rise(act_rise), .act_fall(act_fall),
    .act_en(act_en), .sync_pend(sync_pend), .rdata(rdata)
  );

  frame_pwm_timebase u_tb (
    .clk(clk), .rst(rst), .prescale(prescale), .period(period),
    .tick(tick), .frame_start(frame_start), .next_step(next_step), .step(step)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    frame_pwm_chan u_ch (
      .clk(clk), .rst(rst), .tick(tick), .next_step(next_step),
      .rise(act_rise[i]), .fall(act_fall[i]), .en(act_en[i]),
      .out(pwm_out[i])
    );
  end
endmodule

// File: rtl/frame_pwm_chk.sv
module frame_pwm_chk
  import frame_pwm_pkg::*;
#(
  parameter int             NCH         = 16,
  parameter int             ADDR_W      = 6,
  parameter int             DATA_W      = 32,
  parameter logic [NCH-1:0] SHADOW_MASK = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    act_en,
  input logic              frame_start,
  input logic              sync_pend,
  input step_t             step
);
  logic sync_wr;
  assign sync_wr = wr_en && (addr == ADDR_W'(A_SYNC));

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pwm_out & ~$past(act_en)) == '0)); // R9

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (step == '0)); // R1

  AST_SYNC_SETS: assert property (@(posedge clk) disable iff (rst)
    sync_wr |=> sync_pend); // R8

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (frame_start && sync_pend && !sync_wr) |=> !sync_pend); // R8

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(frame_start && sync_pend) |=> $stable(act_en & SHADOW_MASK)); // R7

  AST_SYNC_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(A_SYNC)) |=> (rdata == '0)); // R10
endmodule

bind frame_pwm frame_pwm_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHADOW_MASK(SHADOW_MASK)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .pwm_out(pwm_out), .act_en(act_en),
  .frame_start(frame_start), .sync_pend(sync_pend), .step(step)
);

// File: tb/sim_frame_pwm.sv
module sim_frame_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NV = 6;
  // {prescale, period, rise, fall, expected high clocks per frame}
  localparam logic [39:0] VEC [NV] = '{
    40'h00_09_02_05_03,   // R2
    40'h01_09_02_05_06,   // R1 R2 prescale scales step
    40'h03_04_01_03_08,   // R1 R2
    40'h00_09_05_02_07,   // R3 inverted
    40'h02_07_00_07_15,   // R1 R2
    40'h00_FE_00_FF_FF    // R5 full-high
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pwm_out;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_pwm u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = 6'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  task automatic measure(input int ch, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, hi, len;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 outputs", int'(pwm_out), 0);
    rst = 1'b0;
    rd(0, v);  check("R11 prescale", v, 0);
    rd(1, v);  check("R11 period", v, 0);
    rd(22, v); check("R11 rise9", v, 0);

    // R12 / R10: map and readback
    wr(0, 32'hFFFF_FF12); rd(0, v); check("R12 prescale word0", v, 8'h12);
    wr(1, 8'h34);  rd(1, v);  check("R12 period word1", v, 8'h34);
    wr(3, 8'h00);  rd(3, v);  check("R12 enable word3", v, 0);
    wr(23, 8'h56); rd(23, v); check("R12 fall9 word23", v, 8'h56);
    wr(57, 1);     rd(57, v); check("R10 sync reads zero", v, 0);

    // table: channel 9 is unshadowed, writes apply at once (R6)
    for (int r = 0; r < NV; r++) begin
      logic [39:0] t;
      t = VEC[r];
      wr(0, int'(t[39:32])); wr(1, int'(t[31:24]));
      wr(22, int'(t[23:16])); wr(23, int'(t[15:8]));
      wr(3, 8'h02);
      len = (int'(t[39:32]) + 1) * (int'(t[31:24]) + 1);
      repeat (2*len + 4) @(negedge clk);
      measure(9, len, hi);
      check($sformatf("R1 R2 R3 R5 R6 row%0d", r), hi, int'(t[7:0]));
    end

    // R4: equal edges toggle once per frame
    wr(0, 0); wr(1, 9); wr(22, 3); wr(23, 3);
    repeat (44) @(negedge clk);
    measure(9, 20, hi); check("R4 equal edges", hi, 10);

    // restore ch9 to rise2 fall5
    wr(22, 2); wr(23, 5);

    // R7: shadowed channel 2 holds staged values
    wr(2, 8'h04); wr(8, 5); wr(9, 8);
    measure(2, 30, hi); check("R7 staged not active", hi, 0);
    rd(8, v); check("R10 staged readback", v, 5);
    wr(57, 1);
    measure(2, 4, hi); check("R7 no change before boundary", hi, 0);
    repeat (25) @(negedge clk);
    measure(2, 10, hi); check("R7 commit at frame start", hi, 3);
    measure(9, 10, hi); check("R7 sync no effect unshadowed", hi, 3);

    // R8: pending cleared, new staged value waits for new request
    wr(8, 6);
    repeat (30) @(negedge clk);
    measure(2, 10, hi); check("R8 no second commit", hi, 3);
    wr(57, 1);
    repeat (30) @(negedge clk);
    measure(2, 10, hi); check("R8 new commit", hi, 2);

    // R9 / R6: disabling unshadowed channel forces low
    wr(3, 8'h00);
    measure(9, 20, hi); check("R9 disabled low", hi, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule